// File: doc/BRIEF.md
# Long Relative Address Unit

This unit forms a 16-bit program-counter-relative target for a three-byte instruction whose operand is a signed 16-bit displacement, supplied as a low byte and a high byte. The displacement is added to the address of the instruction that follows. That address is the instruction address plus 3. The sum wraps modulo 2^16, so the target can be anywhere in a 64K space.

A start strobe launches the operation and an operation select chooses between two uses. A branch loads the target into the program counter through a one-cycle load pulse. A push writes the target to a descending stack over a byte-wide write stream. For each byte, the unit writes at the current stack pointer and then lowers the pointer by one.

The write stream uses valid/ready. A byte counts only in a cycle where valid and ready are both high. While ready is low, the unit keeps valid high and holds the address and data. Fetch and decode sit outside this block.

Top module: `lrel_addr_unit`

## Requirements
- R1: The target equals instruction address + 3 + {off_hi, off_lo}, where the displacement is read as two's complement and the sum wraps modulo 2^16.
- R2: For a branch (op_i = 0), pc_load_o is high for exactly one cycle, in the cycle after start is accepted. In that cycle pc_o carries the target, and no write is issued.
- R3: For a push (op_i = 1), exactly two bytes are written. The first is the high byte of the target, written at the starting stack address. The second is the low byte, written at that address minus one.
- R4: In emulation mode (native_i = 0), the stack address is 0x01 in the upper byte and the pointer's low byte in the lower byte. The decrement wraps inside that page, so a low byte of 0x00 writes at 0x0100 and then 0x01FF. After a push, sp_o ends 2 below the normalized start value.
- R5: In native mode (native_i = 1), the full 16-bit pointer is used and decrements modulo 2^16, so a start of 0x0000 writes at 0x0000 and then 0xFFFF, and sp_o ends at 0xFFFE.
- R6: While wr_valid_o is high and wr_ready_i is low, the next cycle keeps wr_valid_o high with wr_addr_o and wr_data_o unchanged.
- R7: done_o is a one-cycle pulse. For a push it comes in the cycle after the second write is accepted, which is 3 cycles after start when ready stays high. For a branch it comes together with pc_load_o.
- R8: A start strobe seen while an operation is in progress, including the done cycle, is ignored. It produces no extra done, load or write, and it does not change the target or the pointer.
- R9: After reset, wr_valid_o, done_o and pc_load_o are low.
- R10: An instruction at 0x0800 with offset bytes 0xFD (low) and 0xFF (high) yields the target 0x0800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| op_i | input | 1 | 0 = branch, 1 = push |
| native_i | input | 1 | 1 = full 16-bit stack pointer, 0 = page-0x01 stack |
| instr_addr_i | input | 16 | Address of the three-byte instruction |
| off_lo_i | input | 8 | Displacement low byte |
| off_hi_i | input | 8 | Displacement high byte |
| sp_i | input | 16 | Stack pointer at start |
| pc_load_o | output | 1 | Program counter load pulse |
| pc_o | output | 16 | Computed target |
| wr_valid_o | output | 1 | Stack write valid |
| wr_ready_i | input | 1 | Stack write ready |
| wr_addr_o | output | 16 | Stack write address |
| wr_data_o | output | 8 | Stack write byte |
| sp_o | output | 16 | Working stack pointer |
| done_o | output | 1 | Completion pulse |

## Verification
Two things can land in the same cycle: a new start strobe and an operation already in progress. The new strobe can coincide with a stalled write, with the second write, or with the done cycle itself. The bench provokes this by holding start high for several edges after acceptance while it scrambles the operation select, the address and the pointer. Write-ready is randomized in some runs so that the overlap falls on stalls. The result is judged at the ports. The write stream must match the expected queue exactly, and sp_o and pc_o must carry the values of the first request. After done, no further done, load or write may appear.

// File: rtl/lrel_pkg.sv
package lrel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BRANCH = 2'd1,
    ST_PUSH   = 2'd2,
    ST_FIN    = 2'd3
  } lrel_state_t;

  typedef enum logic {
    OP_BRANCH = 1'b0,
    OP_PUSH   = 1'b1
  } lrel_op_t;
endpackage

// File: rtl/lrel_target_calc.sv
module lrel_target_calc #(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int ILEN = 3
) (
  input  logic [AW-1:0] instr_addr_i,
  input  logic [DW-1:0] off_lo_i,
  input  logic [DW-1:0] off_hi_i,
  output logic [AW-1:0] target_o
);
  localparam int OW = 2 * DW;

  logic [OW-1:0] off_raw;
  logic [AW-1:0] off_ext;
  logic [AW-1:0] next_addr;

  assign off_raw = {off_hi_i, off_lo_i};

  // widen by sign extension or narrow to the address width
  generate
    if (AW > OW) begin : g_sext
      assign off_ext = {{(AW-OW){off_raw[OW-1]}}, off_raw};
    end else begin : g_trunc
      assign off_ext = off_raw[AW-1:0];
    end
  endgenerate

  assign next_addr = instr_addr_i + AW'(ILEN);
  assign target_o  = next_addr + off_ext;
endmodule

// File: rtl/lrel_stack_map.sv
module lrel_stack_map #(
  parameter int          AW         = 16,
  parameter int          DW         = 8,
  parameter int unsigned STACK_PAGE = 1
) (
  input  logic [AW-1:0] sp_i,
  input  logic          native_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] dec_o
);
  localparam int PW = AW - DW;
  localparam logic [PW-1:0] PAGE = PW'(STACK_PAGE);

  logic [DW-1:0] low;
  logic [DW-1:0] low_m1;

  assign low    = sp_i[DW-1:0];
  assign low_m1 = low - DW'(1);

  always_comb begin
    if (native_i) begin
      addr_o = sp_i;
      dec_o  = sp_i - AW'(1);
    end else begin
      addr_o = {PAGE, low};
      dec_o  = {PAGE, low_m1};
    end
  end
endmodule

// File: rtl/lrel_ctrl.sv
module lrel_ctrl
  import lrel_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          DW         = 8,
  parameter int unsigned STACK_PAGE = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          op_i,
  input  logic          native_i,
  input  logic [AW-1:0] target_i,
  input  logic [AW-1:0] sp_load_i,
  input  logic [AW-1:0] sp_dec_i,
  input  logic          wr_ready_i,
  output logic          busy_o,
  output logic          mode_o,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] pc_o,
  output logic          pc_load_o,
  output logic          wr_valid_o,
  output logic [DW-1:0] wr_data_o,
  output logic          done_o
);
  localparam int BYTES = AW / DW;
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int PW    = AW - DW;

  lrel_state_t  state_q;
  logic [AW-1:0] target_q;
  logic [AW-1:0] sp_q;
  logic          mode_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      target_q <= '0;
      sp_q     <= '0;
      mode_q   <= 1'b0;
      idx_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            target_q <= target_i;
            sp_q     <= sp_load_i;
            mode_q   <= native_i;
            idx_q    <= IDX_W'(BYTES - 1);
            state_q  <= (lrel_op_t'(op_i) == OP_PUSH) ? ST_PUSH : ST_BRANCH;
          end
        end
        ST_BRANCH: state_q <= ST_IDLE;
        ST_PUSH: begin
          if (wr_ready_i) begin
            sp_q <= sp_dec_i;
            if (idx_q == '0) state_q <= ST_FIN;
            else             idx_q   <= idx_q - IDX_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign mode_o     = mode_q;
  assign sp_o       = sp_q;
  assign pc_o       = target_q;
  assign pc_load_o  = (state_q == ST_BRANCH);
  assign wr_valid_o = (state_q == ST_PUSH);
  assign wr_data_o  = target_q[int'(idx_q)*DW +: DW];
  assign done_o     = (state_q == ST_BRANCH) || (state_q == ST_FIN);

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_data_o) && $stable(sp_q)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2
  branch_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |-> !wr_valid_o);

  // R8
  busy_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(target_q));

  // R5
  native_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_ready_i && mode_q) |=> (sp_q == $past(sp_q) - AW'(1)));

  // R4
  emul_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_ready_i && !mode_q) |=> (sp_q[AW-1:DW] == PW'(STACK_PAGE)));
endmodule

// File: rtl/lrel_addr_unit.sv
module lrel_addr_unit #(
  parameter int          AW         = 16,
  parameter int          DW         = 8,
  parameter int          ILEN       = 3,
  parameter int unsigned STACK_PAGE = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          op_i,
  input  logic          native_i,
  input  logic [AW-1:0] instr_addr_i,
  input  logic [DW-1:0] off_lo_i,
  input  logic [DW-1:0] off_hi_i,
  input  logic [AW-1:0] sp_i,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_o,
  output logic          wr_valid_o,
  input  logic          wr_ready_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic [AW-1:0] sp_o,
  output logic          done_o
);
  logic [AW-1:0] target;
  logic [AW-1:0] map_sp;
  logic          map_mode;
  logic [AW-1:0] map_addr;
  logic [AW-1:0] map_dec;
  logic          busy;
  logic          mode_q;
  logic [AW-1:0] sp_q;

  lrel_target_calc #(.AW(AW), .DW(DW), .ILEN(ILEN)) u_calc (
    .instr_addr_i (instr_addr_i),
    .off_lo_i     (off_lo_i),
    .off_hi_i     (off_hi_i),
    .target_o     (target)
  );

  // idle: normalize the incoming pointer; busy: step the working pointer
  assign map_sp   = busy ? sp_q   : sp_i;
  assign map_mode = busy ? mode_q : native_i;

  lrel_stack_map #(.AW(AW), .DW(DW), .STACK_PAGE(STACK_PAGE)) u_map (
    .sp_i     (map_sp),
    .native_i (map_mode),
    .addr_o   (map_addr),
    .dec_o    (map_dec)
  );

  lrel_ctrl #(.AW(AW), .DW(DW), .STACK_PAGE(STACK_PAGE)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .op_i       (op_i),
    .native_i   (native_i),
    .target_i   (target),
    .sp_load_i  (map_addr),
    .sp_dec_i   (map_dec),
    .wr_ready_i (wr_ready_i),
    .busy_o     (busy),
    .mode_o     (mode_q),
    .sp_o       (sp_q),
    .pc_o       (pc_o),
    .pc_load_o  (pc_load_o),
    .wr_valid_o (wr_valid_o),
    .wr_data_o  (wr_data_o),
    .done_o     (done_o)
  );

  assign wr_addr_o = map_addr;
  assign sp_o      = sp_q;

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_valid_o && !done_o && !pc_load_o));
endmodule

// File: tb/test_lrel_addr_unit.sv
module test_lrel_addr_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start_i, op_i, native_i, wr_ready_i;
  logic [15:0] instr_addr_i, sp_i;
  logic [7:0]  off_lo_i, off_hi_i;
  logic        pc_load_o, wr_valid_o, done_o;
  logic [15:0] pc_o, wr_addr_o, sp_o;
  logic [7:0]  wr_data_o;

  lrel_addr_unit i_lrel_addr_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .native_i(native_i),
    .instr_addr_i(instr_addr_i), .off_lo_i(off_lo_i), .off_hi_i(off_hi_i), .sp_i(sp_i),
    .pc_load_o(pc_load_o), .pc_o(pc_o), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .sp_o(sp_o), .done_o(done_o)
  );

  int total = 0;
  int bad   = 0;
  bit stall = 1'b0;
  logic [23:0] exp_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    #2;
    wr_ready_i = stall ? 1'($urandom % 2) : 1'b1;
  end

  // monitor: scoreboard for the write stream (R3 order, R4/R5 addresses)
  always @(negedge clk) begin
    if (rst_n && wr_valid_o && wr_ready_i) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R3 actual=%h expected=none", {wr_addr_o, wr_data_o});
      end else begin
        chk("R3", {8'h00, wr_addr_o, wr_data_o}, {8'h00, exp_q.pop_front()});
      end
    end
  end

  task automatic run_op(input bit op, input bit nat, input logic [15:0] instr,
                        input logic [15:0] off, input logic [15:0] sp,
                        input int hold, input int exp_cyc, input string tag);
    logic [15:0] tgt, sp0, sp1, spf;
    int cyc;
    logic cap_pcl;
    logic [15:0] cap_pc, cap_sp;
    tgt = instr + 16'd3 + off;
    sp0 = nat ? sp : {8'h01, sp[7:0]};
    sp1 = nat ? sp0 - 16'd1 : {8'h01, sp0[7:0] - 8'd1};
    spf = nat ? sp1 - 16'd1 : {8'h01, sp1[7:0] - 8'd1};
    if (op) begin
      exp_q.push_back({sp0, tgt[15:8]});
      exp_q.push_back({sp1, tgt[7:0]});
    end
    @(posedge clk); #2;
    op_i = op; native_i = nat; instr_addr_i = instr;
    off_lo_i = off[7:0]; off_hi_i = off[15:8]; sp_i = sp; start_i = 1'b1;
    cyc = 0; cap_pcl = 1'b0; cap_pc = '0; cap_sp = '0;
    fork
      begin
        @(posedge clk); #2;
        // scrambled inputs while busy (R8)
        instr_addr_i = instr ^ 16'h5a5a; op_i = ~op; sp_i = sp ^ 16'h00ff; off_lo_i = ~off_lo_i;
        repeat (hold - 1) @(posedge clk);
        #2 start_i = 1'b0;
      end
      begin
        do begin @(negedge clk); cyc++; end while (!done_o && cyc < 200);
        cap_pcl = pc_load_o; cap_pc = pc_o; cap_sp = sp_o;
      end
    join
    start_i = 1'b0;
    chk({"R7 done reached ", tag}, {31'd0, cyc < 200}, 32'd1);
    if (exp_cyc > 0) chk({"R7 latency ", tag}, cyc, exp_cyc);
    if (!op) begin
      chk({"R2 load ", tag}, {31'd0, cap_pcl}, 32'd1);
      chk({"R1 target ", tag}, {16'd0, cap_pc}, {16'd0, tgt});
    end else begin
      chk({"R2 no load on push ", tag}, {31'd0, cap_pcl}, 32'd0);
      chk({(nat ? "R5 sp " : "R4 sp "), tag}, {16'd0, cap_sp}, {16'd0, spf});
      chk({"R3 all written ", tag}, exp_q.size(), 0);
    end
    repeat (3) begin
      @(negedge clk);
      chk({"R8 quiet ", tag}, {29'd0, done_o, pc_load_o, wr_valid_o}, 32'd0);
    end
    if (op) chk({"R8 sp kept ", tag}, {16'd0, sp_o}, {16'd0, spf});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; op_i = 1'b0; native_i = 1'b0; wr_ready_i = 1'b1;
    instr_addr_i = '0; off_lo_i = '0; off_hi_i = '0; sp_i = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset", {29'd0, done_o, pc_load_o, wr_valid_o}, 32'd0);

    // R10 example, branch and push
    run_op(1'b0, 1'b0, 16'h0800, 16'hFFFD, 16'h01FF, 1, 2, "R10 branch");
    run_op(1'b1, 1'b1, 16'h0800, 16'hFFFD, 16'h3000, 1, 4, "R10 push");
    // R1 wrap and extreme displacements
    run_op(1'b0, 1'b1, 16'hFFFE, 16'h0005, 16'h0000, 1, 2, "R1 wrap");
    run_op(1'b0, 1'b0, 16'h1000, 16'h8000, 16'h0000, 1, 2, "R1 min");
    run_op(1'b0, 1'b0, 16'h0000, 16'h7FFF, 16'h0000, 1, 2, "R1 max");
    // R5 native pushes
    run_op(1'b1, 1'b1, 16'h1234, 16'h0010, 16'h2000, 1, 4, "R5 plain");
    run_op(1'b1, 1'b1, 16'h4000, 16'hF000, 16'h0000, 1, 4, "R5 wrap");
    // R4 emulation pushes
    run_op(1'b1, 1'b0, 16'h2222, 16'h0100, 16'h3380, 1, 4, "R4 page");
    run_op(1'b1, 1'b0, 16'hABCD, 16'h0001, 16'h0500, 1, 4, "R4 wrap");
    // R8 start held through busy and done cycles
    run_op(1'b0, 1'b0, 16'h0400, 16'h0020, 16'h0000, 2, 2, "R8 branch");
    run_op(1'b1, 1'b1, 16'h6000, 16'hFF00, 16'h8000, 4, 4, "R8 push");
    // R6 back-pressure with random ready
    stall = 1'b1;
    for (int i = 0; i < 12; i++) begin
      run_op(1'b1, i[0], 16'(i * 16'h1357), 16'(i * 16'h0F0F), 16'(i * 16'h0123), 3, 0, "R6 stall");
    end
    stall = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule